// File: doc/BRIEF.md
# Hybrid Fast/Dense Bank Placement Controller

This block steers cache lines in a banked last-level cache whose banks come in two kinds. Fast banks have short access times and low density. Dense banks are slower but hold more. Banks are grouped into bankclusters. Half of the clusters sit next to the cores and the other half sit in the middle of the array. Every cluster holds one fast bank and one dense bank of each bankset.

The controller accepts three kinds of event, each on its own valid/ready input:
- an eviction from a fast bank,
- a hit naming the bank, the way and the requesting core,
- a line arriving from off-chip memory.

For each accepted event it issues one registered command. The command gives a source bank, a destination bank, a set, the destination way, and what happens to the line already in that way.

New lines always enter a dense bank chosen by their address. Lines reach fast banks only when they are used again. Lines pushed out of a fast bank fall back to their dense partner, so lines leave the cache only from dense banks. The block holds one LRU bit per (bank, set) to pick victim ways. The storage arrays, the network and coherence are not part of this block.

Top module: `nuca_place_ctrl`

## Requirements

Bank identifiers and codes used by all requirements:
- A bank identifier is 5 bits. Bit 4 is 1 for a dense bank and 0 for a fast bank. Bits 3:0 give the cluster.
- Clusters 0..7 are the near clusters; cluster c is adjacent to core c. Clusters 8..15 are the centre clusters; centre cluster 8+c faces near cluster c.
- The set index is the low 2 bits of an event's set or address field. A fill's home cluster is fill_addr[5:2].
- Command kind codes: 0 = touch, 1 = fill, 2 = promote, 3 = demote.
- Victim codes: 0 = none, 1 = swap into the source slot, 2 = leave the cache.

Requirements:
- R1: An accepted fill produces kind 1, with destination equal to the dense bank of the home cluster (bit 4 set, bits 3:0 = fill_addr[5:2]) and victim code 2.
- R2: Victim code 2 only ever appears with a dense destination bank, so no command ever pushes a line out of the cache from a fast bank.
- R3: A hit in a dense bank produces kind 2, with destination equal to the fast bank of the same cluster, source equal to the hit bank, and victim code 1.
- R4: Every promote command targets a fast bank and uses victim code 1, so no line ever moves from one dense bank to another.
- R5: A hit in fast bank of cluster k from core r moves the line one step toward r, with kind 2 and victim code 1:
  - near k≠r goes to centre 8+k;
  - centre 8+j with j=r goes to near r;
  - centre 8+j with j<r goes to centre 9+j;
  - centre 8+j with j>r goes to centre 7+j.
- R6: A hit in near fast bank r from core r produces kind 0, with destination equal to the source, victim code 0 and way equal to hit_way.
- R7: A fast-bank eviction from cluster k produces kind 3, with destination equal to the dense bank of cluster k and victim code 2.
- R8: When events compete, eviction beats hit and hit beats fill. A ready signal is high only when no higher-priority event is valid and the command slot is free.
- R9: While cmd_valid is high and cmd_ready is low, every command field holds its value and no event is accepted.
- R10: For kinds 1, 2 and 3, the destination way is the LRU way of the destination (bank, set) and that way then becomes most recent. For kind 0, the hit way becomes most recent. As a result, two allocations in a row to one bank and set use different ways.
- R11: After reset no command is valid, and the first allocation into any bank and set uses way 0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dem_valid | input | 1 | A fast bank has a victim to place |
| dem_ready | output | 1 | Eviction event accepted this cycle if valid |
| dem_cl | input | 4 | Cluster of the evicting fast bank |
| dem_set | input | 2 | Set of the victim line |
| hit_valid | input | 1 | A hit event is offered |
| hit_ready | output | 1 | Hit event accepted this cycle if valid |
| hit_bank | input | 5 | Bank that hit |
| hit_core | input | 3 | Requesting core |
| hit_way | input | 1 | Way that hit |
| hit_set | input | 2 | Set of the hit line |
| fill_valid | input | 1 | A line arrives from off-chip memory |
| fill_ready | output | 1 | Fill accepted this cycle if valid |
| fill_addr | input | 6 | Low line-address bits: home cluster and set |
| cmd_valid | output | 1 | Command register holds a command |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_kind | output | 2 | Command kind code |
| cmd_vict | output | 2 | Handling of the line in the destination way |
| cmd_src | output | 5 | Bank the line comes from (the destination itself for a fill) |
| cmd_bank | output | 5 | Destination bank |
| cmd_set | output | 2 | Set index |
| cmd_way | output | 1 | Destination way |

## Verification

A wrong LRU bit does not show up on the cycle it is written. It appears only on the next allocation to the same bank and set, as a repeated or wrong cmd_way. For that reason the tests return to a bank and set after a touch or an allocation.

A routing fault shows up on cmd_bank in the cycle right after the event is accepted. An arbitration fault shows up on the ready outputs within the same cycle that the competing valids appear, and also in the order of the commands that follow.

Hold faults under back-pressure only show while cmd_ready stays low. The bench therefore keeps cmd_ready low for several cycles while a second event is waiting.

// File: rtl/nuca_pkg.sv
package nuca_pkg;
  typedef enum logic [1:0] {
    K_TOUCH   = 2'd0,
    K_FILL    = 2'd1,
    K_PROMOTE = 2'd2,
    K_DEMOTE  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    V_NONE  = 2'd0,
    V_SWAP  = 2'd1,
    V_LEAVE = 2'd2
  } vict_e;
endpackage

// File: rtl/nuca_hit_route.sv
module nuca_hit_route
  import nuca_pkg::*;
#(
  parameter int N_NEAR = 8,
  localparam int CORE_W = $clog2(N_NEAR),
  localparam int CL_W   = $clog2(2 * N_NEAR),
  localparam int BANK_W = CL_W + 1
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [CORE_W-1:0] core,
  output logic [BANK_W-1:0] dest,
  output kind_e             kind,
  output vict_e             vict
);
  logic            dense;
  logic [CL_W-1:0] cl;
  logic [CL_W-1:0] ring;
  logic [CL_W-1:0] req;

  assign dense = bank[BANK_W-1];
  assign cl    = bank[CL_W-1:0];
  assign ring  = cl - CL_W'(N_NEAR);
  assign req   = CL_W'(core);

  always_comb begin
    dest = bank;
    kind = K_PROMOTE;
    vict = V_SWAP;
    if (dense) begin
      dest = {1'b0, cl};
    end else if (cl < CL_W'(N_NEAR)) begin
      if (cl == req) begin
        kind = K_TOUCH;
        vict = V_NONE;
      end else begin
        dest = {1'b0, cl + CL_W'(N_NEAR)};
      end
    end else if (ring == req) begin
      dest = {1'b0, req};
    end else if (ring < req) begin
      dest = {1'b0, cl + CL_W'(1)};
    end else begin
      dest = {1'b0, cl - CL_W'(1)};
    end
  end
endmodule

// File: rtl/nuca_arb.sv
module nuca_arb #(
  parameter int N_REQ = 3
) (
  input  logic             free,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] rdy
);
  genvar gi;
  generate
    for (gi = 0; gi < N_REQ; gi++) begin : g_lvl
      if (gi == 0) begin : g_top
        assign rdy[gi] = free;
      end else begin : g_low
        assign rdy[gi] = free & ~(|req[gi-1:0]);
      end
    end
  endgenerate
endmodule

// File: rtl/nuca_lru.sv
module nuca_lru #(
  parameter int N_BANK = 32,
  parameter int SET_W  = 2,
  localparam int BANK_W = $clog2(N_BANK),
  localparam int DEPTH  = N_BANK * (1 << SET_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [SET_W-1:0]  rd_set,
  output logic              rd_lru,
  input  logic              wr_en,
  input  logic              wr_lru
);
  logic [DEPTH-1:0] lru_q;
  logic [BANK_W+SET_W-1:0] idx;

  assign idx    = {rd_bank, rd_set};
  assign rd_lru = lru_q[idx];

  always_ff @(posedge clk) begin
    if (rst) lru_q <= '0;
    else if (wr_en) lru_q[idx] <= wr_lru;
  end
endmodule

// File: rtl/nuca_place_ctrl.sv
module nuca_place_ctrl
  import nuca_pkg::*;
#(
  parameter int N_NEAR = 8,
  parameter int SET_W  = 2,
  localparam int CORE_W = $clog2(N_NEAR),
  localparam int CL_W   = $clog2(2 * N_NEAR),
  localparam int BANK_W = CL_W + 1,
  localparam int N_BANK = 4 * N_NEAR,
  localparam int LINE_W = CL_W + SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dem_valid,
  output logic              dem_ready,
  input  logic [CL_W-1:0]   dem_cl,
  input  logic [SET_W-1:0]  dem_set,
  input  logic              hit_valid,
  output logic              hit_ready,
  input  logic [BANK_W-1:0] hit_bank,
  input  logic [CORE_W-1:0] hit_core,
  input  logic              hit_way,
  input  logic [SET_W-1:0]  hit_set,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [LINE_W-1:0] fill_addr,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [1:0]        cmd_vict,
  output logic [BANK_W-1:0] cmd_src,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [SET_W-1:0]  cmd_set,
  output logic              cmd_way
);
  logic              slot_free;
  logic [2:0]        rdy;
  logic              acc_dem, acc_hit, acc_fill, acc_any;
  logic [BANK_W-1:0] hr_dest;
  kind_e             hr_kind;
  vict_e             hr_vict;
  kind_e             n_kind;
  vict_e             n_vict;
  logic [BANK_W-1:0] n_src, n_bank;
  logic [SET_W-1:0]  n_set;
  logic              n_way, lru_way;

  assign slot_free = ~cmd_valid | cmd_ready;

  nuca_arb #(.N_REQ(3)) u_arb (
    .free (slot_free),
    .req  ({fill_valid, hit_valid, dem_valid}),
    .rdy  (rdy)
  );
  assign dem_ready  = rdy[0];
  assign hit_ready  = rdy[1];
  assign fill_ready = rdy[2];

  assign acc_dem  = dem_valid & dem_ready;
  assign acc_hit  = hit_valid & hit_ready;
  assign acc_fill = fill_valid & fill_ready;
  assign acc_any  = acc_dem | acc_hit | acc_fill;

  nuca_hit_route #(.N_NEAR(N_NEAR)) u_route (
    .bank (hit_bank),
    .core (hit_core),
    .dest (hr_dest),
    .kind (hr_kind),
    .vict (hr_vict)
  );

  always_comb begin
    n_kind = K_FILL;
    n_vict = V_LEAVE;
    n_bank = {1'b1, fill_addr[LINE_W-1:SET_W]};
    n_src  = {1'b1, fill_addr[LINE_W-1:SET_W]};
    n_set  = fill_addr[SET_W-1:0];
    if (dem_valid) begin
      n_kind = K_DEMOTE;
      n_bank = {1'b1, dem_cl};
      n_src  = {1'b0, dem_cl};
      n_set  = dem_set;
    end else if (hit_valid) begin
      n_kind = hr_kind;
      n_vict = hr_vict;
      n_bank = hr_dest;
      n_src  = hit_bank;
      n_set  = hit_set;
    end
  end

  nuca_lru #(.N_BANK(N_BANK), .SET_W(SET_W)) u_lru (
    .clk     (clk),
    .rst     (rst),
    .rd_bank (n_bank),
    .rd_set  (n_set),
    .rd_lru  (lru_way),
    .wr_en   (acc_any),
    .wr_lru  (~n_way)
  );

  assign n_way = (n_kind == K_TOUCH) ? hit_way : lru_way;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_kind  <= 2'd0;
      cmd_vict  <= 2'd0;
      cmd_src   <= '0;
      cmd_bank  <= '0;
      cmd_set   <= '0;
      cmd_way   <= 1'b0;
    end else if (slot_free) begin
      cmd_valid <= acc_any;
      if (acc_any) begin
        cmd_kind <= n_kind;
        cmd_vict <= n_vict;
        cmd_src  <= n_src;
        cmd_bank <= n_bank;
        cmd_set  <= n_set;
        cmd_way  <= n_way;
      end
    end
  end
endmodule

// File: rtl/nuca_place_chk.sv
module nuca_place_chk #(
  parameter int N_NEAR = 8,
  parameter int SET_W  = 2,
  localparam int CL_W   = $clog2(2 * N_NEAR),
  localparam int BANK_W = CL_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              dem_valid,
  input logic              hit_valid,
  input logic              hit_ready,
  input logic              fill_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_kind,
  input logic [1:0]        cmd_vict,
  input logic [BANK_W-1:0] cmd_src,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [SET_W-1:0]  cmd_set,
  input logic              cmd_way
);
  // R2
  leave_dense_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_vict == 2'd2) |-> cmd_bank[BANK_W-1]);

  // R4
  promo_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == 2'd2) |-> (!cmd_bank[BANK_W-1] && cmd_vict == 2'd1));

  // R3
  dense_up_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == 2'd2 && cmd_src[BANK_W-1])
      |-> cmd_bank == {1'b0, cmd_src[CL_W-1:0]});

  // R6
  touch_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == 2'd0) |-> (cmd_bank == cmd_src && cmd_vict == 2'd0));

  // R8
  hit_prio_chk: assert property (@(posedge clk) disable iff (rst)
    hit_ready |-> !dem_valid);

  // R8
  fill_prio_chk: assert property (@(posedge clk) disable iff (rst)
    fill_ready |-> (!dem_valid && !hit_valid));

  // R9
  hold_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_vict)
      && $stable(cmd_src) && $stable(cmd_bank) && $stable(cmd_set) && $stable(cmd_way)));
endmodule

bind nuca_place_ctrl nuca_place_chk #(.N_NEAR(N_NEAR), .SET_W(SET_W)) u_chk (.*);

// File: tb/tb_nuca_place_ctrl.sv
module tb_nuca_place_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dem_valid = 1'b0, hit_valid = 1'b0, fill_valid = 1'b0;
  logic       dem_ready, hit_ready, fill_ready;
  logic [3:0] dem_cl = '0;
  logic [1:0] dem_set = '0, hit_set = '0;
  logic [4:0] hit_bank = '0;
  logic [2:0] hit_core = '0;
  logic       hit_way = 1'b0;
  logic [5:0] fill_addr = '0;
  logic       cmd_valid, cmd_ready = 1'b1;
  logic [1:0] cmd_kind, cmd_vict, cmd_set;
  logic [4:0] cmd_src, cmd_bank;
  logic       cmd_way;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit lru_m [0:127];

  always #2 clk = ~clk;

  nuca_place_ctrl dut (
    .clk(clk), .rst(rst),
    .dem_valid(dem_valid), .dem_ready(dem_ready), .dem_cl(dem_cl), .dem_set(dem_set),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_bank(hit_bank), .hit_core(hit_core),
    .hit_way(hit_way), .hit_set(hit_set),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_vict(cmd_vict),
    .cmd_src(cmd_src), .cmd_bank(cmd_bank), .cmd_set(cmd_set), .cmd_way(cmd_way)
  );

  task automatic cmp(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int alloc_way(int bank, int set);
    int w = lru_m[bank*4+set];
    lru_m[bank*4+set] = ~lru_m[bank*4+set];
    return w;
  endfunction

  task automatic check_cmd(string tag, int kind, int vict, int src, int bank, int set, int way);
    cmp({tag, " valid"}, cmd_valid, 1);
    cmp({tag, " kind"}, cmd_kind, kind);
    cmp({tag, " vict"}, cmd_vict, vict);
    cmp({tag, " src"}, cmd_src, src);
    cmp({tag, " bank"}, cmd_bank, bank);
    cmp({tag, " set"}, cmd_set, set);
    cmp({tag, " way"}, cmd_way, way);
  endtask

  task automatic do_fill(string tag, int addr, int exp_bank);
    int w;
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = 6'(addr);
    @(negedge clk);
    fill_valid = 1'b0;
    w = alloc_way(exp_bank, addr % 4);
    check_cmd(tag, 1, 2, exp_bank, exp_bank, addr % 4, w);
  endtask

  task automatic do_hit(string tag, int bank, int core, int set, int way, int exp_bank);
    int w;
    @(negedge clk);
    hit_valid = 1'b1; hit_bank = 5'(bank); hit_core = 3'(core);
    hit_set = 2'(set); hit_way = way[0];
    @(negedge clk);
    hit_valid = 1'b0;
    if (exp_bank == bank) begin
      lru_m[bank*4+set] = ~way[0];
      check_cmd(tag, 0, 0, bank, bank, set, way);
    end else begin
      w = alloc_way(exp_bank, set);
      check_cmd(tag, 2, 1, bank, exp_bank, set, w);
    end
  endtask

  task automatic do_dem(string tag, int cl, int set);
    int w;
    @(negedge clk);
    dem_valid = 1'b1; dem_cl = 4'(cl); dem_set = 2'(set);
    @(negedge clk);
    dem_valid = 1'b0;
    w = alloc_way(16 + cl, set);
    check_cmd(tag, 3, 2, cl, 16 + cl, set, w);
  endtask

  task automatic t_reset();
    cmp("R11 reset cmd_valid", cmd_valid, 0);
  endtask

  task automatic t_fill();
    do_fill("R1 R11 fill c5 s2 first", 22, 21);
    do_fill("R10 fill c5 s2 second", 22, 21);
    do_fill("R10 fill c5 s2 third", 22, 21);
    do_fill("R1 fill c0 s0", 0, 16);
  endtask

  task automatic t_dense_hit();
    do_hit("R3 dense hit c3", 19, 6, 1, 1, 3);
    do_hit("R3 R4 dense hit centre c12", 28, 0, 2, 0, 12);
  endtask

  task automatic t_gradual();
    do_hit("R5 near2 core5", 2, 5, 0, 0, 10);
    do_hit("R5 centre10 core5", 10, 5, 0, 1, 11);
    do_hit("R5 centre14 core5", 14, 5, 0, 0, 13);
    do_hit("R5 centre13 core5", 13, 5, 0, 0, 5);
    do_hit("R5 centre8 core0", 8, 0, 3, 1, 0);
  endtask

  task automatic t_touch();
    do_hit("R6 near5 core5 touch", 5, 5, 0, 1, 5);
    do_hit("R10 dense hit after touch", 21, 3, 0, 0, 5);
  endtask

  task automatic t_demote();
    do_dem("R7 demote c12 s3", 12, 3);
    do_dem("R7 demote c4 s1", 4, 1);
  endtask

  task automatic t_prio();
    int w;
    @(negedge clk);
    dem_valid = 1'b1; dem_cl = 4'd1; dem_set = 2'd0;
    hit_valid = 1'b1; hit_bank = 5'd17; hit_core = 3'd0; hit_set = 2'd0; hit_way = 1'b0;
    fill_valid = 1'b1; fill_addr = 6'd4;
    #1;
    cmp("R8 dem_ready all valid", dem_ready, 1);
    cmp("R8 hit_ready all valid", hit_ready, 0);
    cmp("R8 fill_ready all valid", fill_ready, 0);
    @(negedge clk);
    dem_valid = 1'b0;
    w = alloc_way(17, 0);
    check_cmd("R8 first demote", 3, 2, 1, 17, 0, w);
    #1;
    cmp("R8 hit_ready after demote", hit_ready, 1);
    cmp("R8 fill_ready behind hit", fill_ready, 0);
    @(negedge clk);
    hit_valid = 1'b0;
    w = alloc_way(1, 0);
    check_cmd("R8 second promote", 2, 1, 17, 1, 0, w);
    @(negedge clk);
    fill_valid = 1'b0;
    w = alloc_way(17, 0);
    check_cmd("R8 R10 third fill", 1, 2, 17, 17, 0, w);
  endtask

  task automatic t_backpressure();
    int wf, wh;
    @(negedge clk);
    cmd_ready = 1'b0;
    fill_valid = 1'b1; fill_addr = 6'd37;
    @(negedge clk);
    fill_valid = 1'b0;
    wf = alloc_way(25, 1);
    check_cmd("R9 held fill", 1, 2, 25, 25, 1, wf);
    hit_valid = 1'b1; hit_bank = 5'd9; hit_core = 3'd1; hit_set = 2'd1; hit_way = 1'b0;
    #1;
    cmp("R9 hit_ready blocked", hit_ready, 0);
    @(negedge clk);
    check_cmd("R9 still held", 1, 2, 25, 25, 1, wf);
    @(negedge clk);
    check_cmd("R9 held again", 1, 2, 25, 25, 1, wf);
    cmd_ready = 1'b1;
    #1;
    cmp("R9 hit_ready after release", hit_ready, 1);
    @(negedge clk);
    hit_valid = 1'b0;
    wh = alloc_way(1, 1);
    check_cmd("R5 R9 centre9 core1 after release", 2, 1, 9, 1, 1, wh);
    @(negedge clk);
    cmp("R9 slot empties", cmd_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) lru_m[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_fill();
    t_dense_hit();
    t_gradual();
    t_touch();
    t_demote();
    t_prio();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule